// File: doc/BRIEF.md
# JTAG TAP State Navigator

This block is the master side of a test-access port. It keeps its own copy of the state of the target's 16-state TAP controller. It generates TCK from the system clock and drives TMS so that the target walks to a requested state. A caller places a command on the command port and pulses a start strobe. The three commands are: go to a state, go to a stable state and hold there for N TCK cycles, or release the port. The block raises `busy` while it works and pulses `done` when it finishes. An error flag reports a navigation that ran out of steps.

The next TMS bit comes from a fixed 16-bit mask for each current state, indexed by the target state. The next tracked state comes from the standard TAP transition rules and updates on each TCK rising edge. After reset the target's state counts as unknown. The first command therefore forces the target into Run-Test/Idle before it does anything else. Data shifting is not part of this block, and TDI stays low.

Top module: `tap_nav`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `err`, `tck`, `tms` and `state_known` are all 0.
- R2: A go-to or wait command that starts while the state is unknown first issues five TCK cycles with TMS=1, then one with TMS=0. The block then reports `state_known`=1 with the tracked state at Run-Test/Idle before it navigates.
- R3: `cur_state` uses this code: 0 test-logic-reset, 1 run-test/idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. `cmd_op` uses 0 or 3 for go-to, 1 for wait and 2 for release.
- R4: For each navigation step, TMS is bit [target] of a mask picked by the current state code. The masks for codes 0 to 15 are 0001, FFFD, FE01, FFE7, FFEF, FF0F, FFBF, FFFF, FEFD, 0001, F3FF, F7FF, 87FF, DFFF, FFFF, 7FFD (hex).
- R5: Each step is exactly one TCK pulse. `cur_state` moves by the standard TAP transition for the TMS value, on the system clock in which TCK rises, and at no other time while the state is known.
- R6: A go-to whose target equals the current state issues one TCK with TMS=0 for states 1, 4, 6, 11 and 13. It issues one TCK with TMS=1 for state 0. It issues no TCK for any other state.
- R7: Navigation gives up after MAX_STEPS steps (9 by default) if the target has not been reached. `err` is then set together with `done`. `err` stays set until the next accepted start, which clears it.
- R8: A wait command navigates to its state only if the block is not already there, with no dwell pulse. It then issues `cmd_hold` TCK cycles with TMS=1 if the state is 0, and TMS=0 otherwise. A count of 0 gives only the navigation.
- R9: A release command issues five TCK cycles with TMS=1 and then reports `state_known`=0. The next go-to or wait starts again with the R2 sequence.
- R10: TCK stays high for exactly `tck_half`+1 system clocks and low for at least `tck_half`+1. TMS changes only while TCK is low. TCK stays low whenever `busy` is 0.
- R11: A start while `busy` is 1 has no effect. `done` is a single-clock pulse in the same cycle in which `busy` falls.
- R12: `tdi` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0/3 go-to, 1 wait, 2 release |
| cmd_state | input | 4 | Target TAP state code (R3) |
| cmd_hold | input | CNT_W | Hold cycle count for wait |
| tck_half | input | DIV_W | TCK half period minus one, in system clocks |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in, held low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last command ran out of navigation steps |
| cur_state | output | 4 | Tracked TAP state |
| state_known | output | 1 | Tracked state is valid |

## Verification
The bench runs its own TAP model, which follows only the `tck` and `tms` pins. A wrong transition entry or a mis-timed state update therefore shows up as a `cur_state` mismatch in the very clock in which TCK rises. A wrong mask bit or dwell rule produces a TMS value at the rising edge that differs from the sequence the bench built from the requirements. The bench flags it on that edge, and it also flags any extra or missing pulse when `done` arrives. All 256 start/target pairs are walked. A short-limit instance forces the step-limit error.

// File: rtl/tap_nav.sv
module tap_nav #(
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 16,
  parameter int MAX_STEPS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_op,
  input  logic [3:0]       cmd_state,
  input  logic [CNT_W-1:0] cmd_hold,
  input  logic [DIV_W-1:0] tck_half,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [3:0]       cur_state,
  output logic             state_known
);

  localparam int SYNC_HIGH = 5;
  localparam int LIM  = (MAX_STEPS > SYNC_HIGH + 1) ? MAX_STEPS : SYNC_HIGH + 1;
  localparam int SC_W = $clog2(LIM + 1);

  localparam logic [3:0] TS_RESET   = 4'd0;
  localparam logic [3:0] TS_IDLE    = 4'd1;
  localparam logic [3:0] TS_DRSHIFT = 4'd4;
  localparam logic [3:0] TS_DRPAUSE = 4'd6;
  localparam logic [3:0] TS_IRSHIFT = 4'd11;
  localparam logic [3:0] TS_IRPAUSE = 4'd13;

  localparam logic [15:0] PATH_MASK [16] = '{
    16'h0001, 16'hFFFD, 16'hFE01, 16'hFFE7, 16'hFFEF, 16'hFF0F, 16'hFFBF, 16'hFFFF,
    16'hFEFD, 16'h0001, 16'hF3FF, 16'hF7FF, 16'h87FF, 16'hDFFF, 16'hFFFF, 16'h7FFD
  };

  typedef enum logic [2:0] {P_IDLE, P_SYNC, P_NAV, P_HOLD, P_REL} phase_t;

  function automatic logic [3:0] tap_next(input logic [3:0] s, input logic m);
    case (s)
      4'd0:    tap_next = m ? 4'd0  : 4'd1;
      4'd1:    tap_next = m ? 4'd2  : 4'd1;
      4'd2:    tap_next = m ? 4'd9  : 4'd3;
      4'd3:    tap_next = m ? 4'd5  : 4'd4;
      4'd4:    tap_next = m ? 4'd5  : 4'd4;
      4'd5:    tap_next = m ? 4'd8  : 4'd6;
      4'd6:    tap_next = m ? 4'd7  : 4'd6;
      4'd7:    tap_next = m ? 4'd8  : 4'd4;
      4'd8:    tap_next = m ? 4'd2  : 4'd1;
      4'd9:    tap_next = m ? 4'd0  : 4'd10;
      4'd10:   tap_next = m ? 4'd12 : 4'd11;
      4'd11:   tap_next = m ? 4'd12 : 4'd11;
      4'd12:   tap_next = m ? 4'd15 : 4'd13;
      4'd13:   tap_next = m ? 4'd14 : 4'd13;
      4'd14:   tap_next = m ? 4'd15 : 4'd11;
      default: tap_next = m ? 4'd2  : 4'd1;
    endcase
  endfunction

  phase_t           phase;
  logic [3:0]       tgt;
  logic             is_wait;
  logic [CNT_W-1:0] hold_left;
  logic [SC_W-1:0]  cnt;
  logic [DIV_W-1:0] hc;
  logic             stepping;

  logic go, go_tms, to_nav, to_hold, fin, fail;

  wire at_tgt   = (cur_state == tgt);
  wire tms_path = PATH_MASK[cur_state][tgt];
  wire dwell    = (tgt == TS_RESET) || (tgt == TS_IDLE) || (tgt == TS_DRSHIFT) ||
                  (tgt == TS_DRPAUSE) || (tgt == TS_IRSHIFT) || (tgt == TS_IRPAUSE);

  assign busy = (phase != P_IDLE);
  assign tdi  = 1'b0;

  always_comb begin
    go = 1'b0; go_tms = 1'b0; to_nav = 1'b0; to_hold = 1'b0; fin = 1'b0; fail = 1'b0;
    case (phase)
      P_SYNC:
        if (cnt <= SC_W'(SYNC_HIGH)) begin
          go = 1'b1;
          go_tms = (cnt < SC_W'(SYNC_HIGH));
        end else to_nav = 1'b1;
      P_NAV:
        if (at_tgt && cnt == '0 && !is_wait && dwell) begin
          go = 1'b1;
          go_tms = (tgt == TS_RESET);
        end else if (at_tgt) begin
          if (is_wait) to_hold = 1'b1;
          else fin = 1'b1;
        end else if (cnt == SC_W'(MAX_STEPS)) begin
          fin = 1'b1;
          fail = 1'b1;
        end else begin
          go = 1'b1;
          go_tms = tms_path;
        end
      P_HOLD:
        if (hold_left != '0) begin
          go = 1'b1;
          go_tms = (tgt == TS_RESET);
        end else fin = 1'b1;
      P_REL:
        if (cnt < SC_W'(SYNC_HIGH)) begin
          go = 1'b1;
          go_tms = 1'b1;
        end else fin = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= P_IDLE;
      tgt         <= TS_RESET;
      is_wait     <= 1'b0;
      hold_left   <= '0;
      cnt         <= '0;
      hc          <= '0;
      stepping    <= 1'b0;
      tck         <= 1'b0;
      tms         <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      cur_state   <= TS_RESET;
      state_known <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == P_IDLE) begin
        if (cmd_start) begin
          tgt       <= cmd_state;
          hold_left <= cmd_hold;
          is_wait   <= (cmd_op == 2'd1);
          err       <= 1'b0;
          cnt       <= '0;
          if (cmd_op == 2'd2)    phase <= P_REL;
          else if (!state_known) phase <= P_SYNC;
          else                   phase <= P_NAV;
        end
      end else if (stepping) begin
        if (hc == tck_half) begin
          hc <= '0;
          if (!tck) begin
            tck <= 1'b1;
            if (phase == P_SYNC) cur_state <= tms ? TS_RESET : TS_IDLE;
            else                 cur_state <= tap_next(cur_state, tms);
          end else begin
            tck      <= 1'b0;
            stepping <= 1'b0;
            cnt      <= cnt + 1'b1;
          end
        end else hc <= hc + 1'b1;
      end else begin
        if (go) begin
          stepping <= 1'b1;
          hc       <= '0;
          tms      <= go_tms;
          if (phase == P_HOLD) hold_left <= hold_left - 1'b1;
        end
        if (to_nav) begin
          state_known <= 1'b1;
          cnt         <= '0;
          phase       <= P_NAV;
        end
        if (to_hold) phase <= P_HOLD;
        if (fin) begin
          phase <= P_IDLE;
          done  <= 1'b1;
          err   <= fail;
          if (phase == P_REL) state_known <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tap_nav_chk.sv
module tap_nav_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tck,
  input logic       tms,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] cur_state,
  input logic       state_known
);

  // R10
  tms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> $stable(tms));

  // R10
  tck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  state_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_known && $past(state_known) && !$stable(cur_state)) |-> $rose(tck));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

endmodule

bind tap_nav tap_nav_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .busy(busy), .done(done),
  .err(err), .cur_state(cur_state), .state_known(state_known)
);

// File: tb/tap_nav_test.sv
module tap_nav_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_state = 4'd0;
  logic [15:0] cmd_hold = 16'd0;
  logic [7:0] tck_half = 8'd1;

  logic tck, tms, tdi, busy, done, err, state_known;
  logic [3:0] cur_state;
  logic s_tck, s_tms, s_tdi, s_busy, s_done, s_err, s_known;
  logic [3:0] s_state;

  tap_nav uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_state(cmd_state), .cmd_hold(cmd_hold), .tck_half(tck_half),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done), .err(err),
    .cur_state(cur_state), .state_known(state_known));

  tap_nav #(.MAX_STEPS(3)) uut_short (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_state(cmd_state), .cmd_hold(cmd_hold), .tck_half(tck_half),
    .tck(s_tck), .tms(s_tms), .tdi(s_tdi), .busy(s_busy), .done(s_done), .err(s_err),
    .cur_state(s_state), .state_known(s_known));

  always #(CLK_P/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] mask_tab [16] = '{
    16'h0001, 16'hFFFD, 16'hFE01, 16'hFFE7, 16'hFFEF, 16'hFF0F, 16'hFFBF, 16'hFFFF,
    16'hFEFD, 16'h0001, 16'hF3FF, 16'hF7FF, 16'h87FF, 16'hDFFF, 16'hFFFF, 16'h7FFD
  };

  function automatic int tap_step(input int s, input bit m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      3: return m ? 5 : 4;
      4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      8: return m ? 2 : 1;
      9: return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  bit exp_q[$];
  int m_state = 0;
  bit m_known = 0;
  int tap_pin = 4;
  bit prev_tck = 0, prev_tms = 0;
  int hi_len = 0, lo_len = 0;
  bit s_done_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tdi == 1'b0, "R12 tdi low", tdi, 0);
      if (!busy) chk(tck == 1'b0, "R10 tck idle low", tck, 0);
      if (tck && !prev_tck) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected TCK pulse", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(tms == e, "R4 TMS at rising edge", tms, e);
        end
        chk(lo_len >= int'(tck_half) + 1, "R10 low width", lo_len, int'(tck_half) + 1);
        tap_pin = tap_step(tap_pin, tms);
        hi_len = 1;
      end else if (tck && prev_tck) begin
        chk(tms == prev_tms, "R10 TMS stable while high", tms, prev_tms);
        hi_len++;
      end else if (!tck && prev_tck) begin
        chk(hi_len == int'(tck_half) + 1, "R10 high width", hi_len, int'(tck_half) + 1);
        lo_len = 1;
      end else lo_len++;
      if (state_known) chk(int'(cur_state) == tap_pin, "R5 tracked state vs pins", cur_state, tap_pin);
      prev_tck = tck;
      prev_tms = tms;
      if (s_done) s_done_seen = 1;
    end
  end

  task automatic run_cmd(input int op, input int tgt, input int n, input string tag);
    int st;
    bit eerr;
    int t;
    eerr = 0;
    st = m_state;
    if (op == 2) begin
      repeat (5) exp_q.push_back(1'b1);
    end else begin
      if (!m_known) begin
        repeat (5) exp_q.push_back(1'b1);
        exp_q.push_back(1'b0);
        st = 1;
      end
      if (st == tgt) begin
        if (op != 1 && (tgt inside {0, 1, 4, 6, 11, 13})) exp_q.push_back(tgt == 0);
      end else begin
        for (int k = 0; k < 9 && st != tgt; k++) begin
          bit b;
          b = mask_tab[st][tgt];
          exp_q.push_back(b);
          st = tap_step(st, b);
        end
        eerr = (st != tgt);
      end
      if (op == 1 && !eerr) repeat (n) exp_q.push_back(tgt == 0);
    end
    cmd_op = op[1:0];
    cmd_state = tgt[3:0];
    cmd_hold = n[15:0];
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 1'b1, {tag, " R11 busy after start"}, busy, 1);
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, {tag, " R11 done reached"}, t, 0);
    chk(busy == 1'b0, {tag, " R11 busy low at done"}, busy, 0);
    chk(exp_q.size() == 0, {tag, " missing TCK pulses"}, exp_q.size(), 0);
    chk(err == eerr, {tag, " R7 err"}, err, eerr);
    m_known = (op != 2);
    m_state = st;
    chk(state_known == m_known, {tag, " R9 state_known"}, state_known, m_known);
    if (m_known) chk(int'(cur_state) == st, {tag, " R3 final state"}, cur_state, st);
    exp_q.delete();
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11 done single pulse"}, done, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(err == 0, "R1 err", err, 0);
    chk(tck == 0, "R1 tck", tck, 0);
    chk(tms == 0, "R1 tms", tms, 0);
    chk(state_known == 0, "R1 state_known", state_known, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && state_known == 0, "R1 after release", busy, 0);

    run_cmd(0, 4, 0, "R2 first goto");
    s_done_seen = 0;
    run_cmd(0, 0, 0, "R4 to reset");
    chk(s_done_seen == 1, "R7 short done seen", s_done_seen, 1);
    chk(s_err == 1, "R7 step limit err", s_err, 1);
    chk(s_state == 4'd2, "R7 state at give-up", s_state, 2);

    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 16; t++) begin
        run_cmd(0, s, 0, "R4 sweep setup");
        run_cmd(0, t, 0, (s == t) ? "R6 dwell" : "R4 sweep");
      end

    run_cmd(1, 1, 7, "R8 wait idle");
    run_cmd(1, 0, 4, "R8 wait reset");
    run_cmd(1, 6, 0, "R8 wait zero");
    run_cmd(0, 11, 0, "R4 goto irshift");
    run_cmd(1, 11, 3, "R8 wait in place");

    run_cmd(2, 0, 0, "R9 release");
    run_cmd(0, 13, 0, "R9 R2 resync");

    fork
      run_cmd(1, 1, 30, "R11 start ignored");
      begin
        repeat (20) @(negedge clk);
        cmd_op = 2'd2;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
      end
    join

    tck_half = 8'd3;
    run_cmd(0, 8, 0, "R10 slow goto");
    run_cmd(1, 6, 5, "R10 slow wait");
    tck_half = 8'd0;
    run_cmd(0, 2, 0, "R10 fast goto");
    run_cmd(0, 0, 0, "R10 fast reset");
    tck_half = 8'd1;
    run_cmd(2, 0, 0, "R9 final release");

    summary();
    $finish;
  end
endmodule